// File: doc/BRIEF.md
# Capture/Compare Event Flag Register

This block keeps one sticky status flag per timer general register. Each register works either as an output compare register or as an input capture register. In compare mode, its flag sets on a cycle where the counter-equals-register strobe is high. In capture mode, its flag sets when a capture strobe latches the counter into the register. Each flag drives an interrupt request while it is 1 and its enable bit is set.

Software clears a flag in two steps. It reads the register while the flag is 1, and it then writes 0 to that bit. A transfer controller that services the flag's interrupt can also clear the flag with an acknowledge pulse. A common keep bit suppresses that clear. A build parameter selects the channel variant. In the reduced variant, the upper flags are reserved: they read 0, never set, never request an interrupt and ignore writes.

The bus port is a plain register port with single-cycle read and write strobes. It carries no data stream, so it has no valid/ready handshake and no back-pressure. Read data is combinational and shows the current flags in the same cycle.

Top module: `ccsf_status_reg`

## Requirements
- R1: While `rst_n` is low, every flag and every interrupt request is 0 from the next clock edge onward.
- R2: When `cap_mode[i]` is 0 (compare), a high `cmp_hit[i]` at a clock edge makes flag i read 1 after that edge. A high `cap_strobe[i]` has no effect in this mode.
- R3: When `cap_mode[i]` is 1 (capture), a high `cap_strobe[i]` at an edge sets flag i. A high `cmp_hit[i]` has no effect in this mode.
- R4: Writing 1 to a flag bit leaves that flag unchanged.
- R5: Writing 0 to a flag bit does not clear it unless a read captured that bit as 1 after the most recent write.
- R6: A read arms bit i when flag i is 1. The next write clears every armed bit written as 0. Any write, whatever its data, disarms all bits. When a read and a write share a cycle, the write uses the earlier arm state and the read arms nothing.
- R7: A high `xfer_ack[i]` clears flag i when `xfer_irq_keep` is 0. It has no effect when `xfer_irq_keep` is 1.
- R8: If a set event for bit i coincides with a software or transfer clear of bit i, the flag is 1 after the edge.
- R9: `irq_req[i]` equals flag i AND `irq_en[i]` in every cycle.
- R10: When `UPPER_PRESENT` is 0, bits at and above `BASE_REGS` read 0 and never set. Their `irq_req` bits stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd | input | 1 | Register read strobe; arms bits that read 1 |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | NUM_REGS | Write data; a 0 bit requests a clear |
| bus_rdata | output | NUM_REGS | Current flags |
| cmp_hit | input | NUM_REGS | Counter-equals-register strobes |
| cap_strobe | input | NUM_REGS | Capture strobes |
| cap_mode | input | NUM_REGS | 1 = capture mode, 0 = compare mode, per register |
| xfer_ack | input | NUM_REGS | Transfer controller acknowledge, per flag |
| xfer_irq_keep | input | 1 | 1 suppresses transfer-acknowledge clears |
| irq_en | input | NUM_REGS | Interrupt enables |
| irq_req | output | NUM_REGS | Interrupt requests |

## Verification
The assertions check on every cycle that each compare or capture strobe sets its flag, and that a set beats a coinciding clear. They also check that a flag falls only after a write of 0 or an ungated acknowledge, that a read of 1 followed directly by a write of 0 clears, that interrupt requests follow the gated flags, and that reserved bits stay at 0. Only the bench scenarios show three behaviours: a write disarms every bit even when it writes 1, a write of 0 with no prior read is rejected, and the mode select masks the unused strobe. The bench also checks the reduced variant end to end.

// File: rtl/ccsf_pkg.sv
package ccsf_pkg;

  typedef enum logic {
    MODE_COMPARE = 1'b0,
    MODE_CAPTURE = 1'b1
  } reg_mode_e;

  // Mask with a 1 for every implemented flag position.
  function automatic logic [31:0] impl_mask(input int unsigned nregs,
                                            input int unsigned base,
                                            input bit upper_present);
    logic [31:0] m;
    m = '0;
    for (int unsigned k = 0; k < 32; k++) begin
      if (k < nregs && (upper_present || k < base)) m[k] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/ccsf_event_sel.sv
module ccsf_event_sel
  import ccsf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4
) (
  input  logic [NUM_REGS-1:0] cmp_hit,
  input  logic [NUM_REGS-1:0] cap_strobe,
  input  logic [NUM_REGS-1:0] cap_mode,
  input  logic [NUM_REGS-1:0] impl,
  output logic [NUM_REGS-1:0] set_req
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    reg_mode_e mode;
    assign mode = reg_mode_e'(cap_mode[i]);
    always_comb begin
      unique case (mode)
        MODE_CAPTURE: set_req[i] = cap_strobe[i] & impl[i];
        default:      set_req[i] = cmp_hit[i] & impl[i];
      endcase
    end
  end

endmodule

// File: rtl/ccsf_clear_ctrl.sv
module ccsf_clear_ctrl #(
  parameter int unsigned NUM_REGS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [NUM_REGS-1:0] bus_wdata,
  input  logic [NUM_REGS-1:0] flags,
  input  logic [NUM_REGS-1:0] impl,
  input  logic [NUM_REGS-1:0] xfer_ack,
  input  logic                xfer_irq_keep,
  output logic [NUM_REGS-1:0] clr_req
);

  logic [NUM_REGS-1:0] arm_q;
  logic [NUM_REGS-1:0] sw_clr;
  logic [NUM_REGS-1:0] xf_clr;

  // A write consumes the arm state; a read only arms if no write is present.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arm_q <= '0;
    else if (bus_wr) arm_q <= '0;
    else if (bus_rd) arm_q <= flags & impl;
  end

  assign sw_clr  = {NUM_REGS{bus_wr}} & ~bus_wdata & arm_q;
  assign xf_clr  = xfer_ack & {NUM_REGS{~xfer_irq_keep}};
  assign clr_req = (sw_clr | xf_clr) & impl;

endmodule

// File: rtl/ccsf_flag_bank.sv
module ccsf_flag_bank #(
  parameter int unsigned NUM_REGS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] impl,
  input  logic [NUM_REGS-1:0] set_req,
  input  logic [NUM_REGS-1:0] clr_req,
  output logic [NUM_REGS-1:0] flags
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (set_req[i]) flag_q <= 1'b1;   // set has priority over clear
      else if (clr_req[i]) flag_q <= 1'b0;
    end
    assign flags[i] = flag_q & impl[i];
  end

endmodule

// File: rtl/ccsf_status_reg.sv
module ccsf_status_reg
  import ccsf_pkg::*;
#(
  parameter int unsigned NUM_REGS      = 4,
  parameter int unsigned BASE_REGS     = 2,
  parameter bit          UPPER_PRESENT = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [NUM_REGS-1:0] bus_wdata,
  output logic [NUM_REGS-1:0] bus_rdata,
  input  logic [NUM_REGS-1:0] cmp_hit,
  input  logic [NUM_REGS-1:0] cap_strobe,
  input  logic [NUM_REGS-1:0] cap_mode,
  input  logic [NUM_REGS-1:0] xfer_ack,
  input  logic                xfer_irq_keep,
  input  logic [NUM_REGS-1:0] irq_en,
  output logic [NUM_REGS-1:0] irq_req
);

  localparam logic [31:0] MASK32 = impl_mask(NUM_REGS, BASE_REGS, UPPER_PRESENT);
  localparam logic [NUM_REGS-1:0] IMPL = MASK32[NUM_REGS-1:0];

  logic [NUM_REGS-1:0] set_req;
  logic [NUM_REGS-1:0] clr_req;
  logic [NUM_REGS-1:0] flags;

  ccsf_event_sel #(.NUM_REGS(NUM_REGS)) u_sel (
    .cmp_hit    (cmp_hit),
    .cap_strobe (cap_strobe),
    .cap_mode   (cap_mode),
    .impl       (IMPL),
    .set_req    (set_req)
  );

  ccsf_clear_ctrl #(.NUM_REGS(NUM_REGS)) u_clr (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .flags         (flags),
    .impl          (IMPL),
    .xfer_ack      (xfer_ack),
    .xfer_irq_keep (xfer_irq_keep),
    .clr_req       (clr_req)
  );

  ccsf_flag_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .impl    (IMPL),
    .set_req (set_req),
    .clr_req (clr_req),
    .flags   (flags)
  );

  assign bus_rdata = flags;
  assign irq_req   = flags & irq_en & IMPL;

endmodule

// File: rtl/ccsf_status_reg_chk.sv
module ccsf_status_reg_chk
  import ccsf_pkg::*;
#(
  parameter int unsigned NUM_REGS      = 4,
  parameter int unsigned BASE_REGS     = 2,
  parameter bit          UPPER_PRESENT = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_rd,
  input logic                bus_wr,
  input logic [NUM_REGS-1:0] bus_wdata,
  input logic [NUM_REGS-1:0] bus_rdata,
  input logic [NUM_REGS-1:0] cmp_hit,
  input logic [NUM_REGS-1:0] cap_strobe,
  input logic [NUM_REGS-1:0] cap_mode,
  input logic [NUM_REGS-1:0] xfer_ack,
  input logic                xfer_irq_keep,
  input logic [NUM_REGS-1:0] irq_en,
  input logic [NUM_REGS-1:0] irq_req
);

  localparam logic [31:0] MASK32 = impl_mask(NUM_REGS, BASE_REGS, UPPER_PRESENT);
  localparam logic [NUM_REGS-1:0] IMPL = MASK32[NUM_REGS-1:0];

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (bus_rdata == '0 && irq_req == '0));

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (bus_rdata & irq_en));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      assert_cmp_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_mode[i] && cmp_hit[i]) |=> bus_rdata[i]);

      assert_cap_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode[i] && cap_strobe[i]) |=> bus_rdata[i]);

      assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (((!cap_mode[i] && cmp_hit[i]) || (cap_mode[i] && cap_strobe[i])) &&
         ((bus_wr && !bus_wdata[i]) || xfer_ack[i])) |=> bus_rdata[i]);

      assert_clear_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rdata[i]) |->
          ($past(bus_wr && !bus_wdata[i]) || $past(xfer_ack[i] && !xfer_irq_keep)));

      assert_read_write_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_rd && !bus_wr && bus_rdata[i]) && bus_wr && !bus_wdata[i] &&
         !cmp_hit[i] && !cap_strobe[i]) |=> !bus_rdata[i]);

      assert_xfer_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ack[i] && !xfer_irq_keep && !cmp_hit[i] && !cap_strobe[i]) |=> !bus_rdata[i]);
    end else begin : g_rsv
      assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata[i] && !irq_req[i]);
    end
  end

endmodule

bind ccsf_status_reg ccsf_status_reg_chk #(
  .NUM_REGS      (NUM_REGS),
  .BASE_REGS     (BASE_REGS),
  .UPPER_PRESENT (UPPER_PRESENT)
) u_chk (.*);

// File: tb/ccsf_status_reg_bench.sv
module ccsf_status_reg_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic [3:0] wd;
    logic [3:0] cmp;
    logic [3:0] cap;
    logic [3:0] mode;
    logic [3:0] ack;
    logic       keep;
    logic [3:0] en;
    logic [3:0] exp;
  } vec_t;

  // Flags after the edge of each vector; bit 0 = register A.
  localparam vec_t VECS [17] = '{
    '{1'b0,1'b0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,4'hF,4'h0}, // R1 idle after reset
    '{1'b0,1'b0,4'h0,4'h1,4'h0,4'h0,4'h0,1'b0,4'hF,4'h1}, // R2 compare set A
    '{1'b0,1'b0,4'h0,4'h2,4'h0,4'h2,4'h0,1'b0,4'hF,4'h1}, // R3 match ignored in capture mode
    '{1'b0,1'b0,4'h0,4'h0,4'h2,4'h2,4'h0,1'b0,4'hF,4'h3}, // R3 capture set B
    '{1'b0,1'b1,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,4'hF,4'h3}, // R5 write 0, no prior read
    '{1'b1,1'b0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,4'hF,4'h3}, // R6 read arms A,B
    '{1'b0,1'b1,4'hF,4'h0,4'h0,4'h0,4'h0,1'b0,4'hF,4'h3}, // R4 write 1s, disarms
    '{1'b0,1'b1,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,4'hF,4'h3}, // R6 arm consumed
    '{1'b1,1'b0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,4'hF,4'h3}, // R6 read again
    '{1'b0,1'b1,4'hE,4'h0,4'h0,4'h0,4'h0,1'b0,4'hF,4'h2}, // R6 clear A only
    '{1'b0,1'b0,4'h0,4'h4,4'h0,4'h0,4'h0,1'b0,4'hF,4'h6}, // R2 compare set C
    '{1'b0,1'b0,4'h0,4'h0,4'h0,4'h0,4'h4,1'b1,4'hF,4'h6}, // R7 ack with keep=1
    '{1'b0,1'b0,4'h0,4'h0,4'h0,4'h0,4'h4,1'b0,4'hF,4'h2}, // R7 ack with keep=0
    '{1'b1,1'b0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,4'h2,4'h2}, // R9 read arms B, en=B
    '{1'b0,1'b1,4'h0,4'h0,4'h2,4'h2,4'h0,1'b0,4'h0,4'h2}, // R8 capture vs sw clear
    '{1'b0,1'b0,4'h0,4'h8,4'h0,4'h0,4'h8,1'b0,4'hA,4'hA}, // R8 match vs ack clear
    '{1'b0,1'b0,4'h0,4'h0,4'h8,4'h0,4'h0,1'b0,4'h8,4'hA}  // R2 capture ignored in compare mode
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd, wr, keep;
  logic [3:0] wd, cmp, cap, mode, ack, en, rdata, irq;
  logic       r_rd, r_wr;
  logic [3:0] r_wd, r_cmp, r_rdata, r_irq;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccsf_status_reg u_ccsf_status_reg (
    .clk(clk), .rst_n(rst_n), .bus_rd(rd), .bus_wr(wr), .bus_wdata(wd),
    .bus_rdata(rdata), .cmp_hit(cmp), .cap_strobe(cap), .cap_mode(mode),
    .xfer_ack(ack), .xfer_irq_keep(keep), .irq_en(en), .irq_req(irq)
  );

  ccsf_status_reg #(.UPPER_PRESENT(1'b0)) u_ccsf_status_reg_rsv (
    .clk(clk), .rst_n(rst_n), .bus_rd(r_rd), .bus_wr(r_wr), .bus_wdata(r_wd),
    .bus_rdata(r_rdata), .cmp_hit(r_cmp), .cap_strobe(4'h0), .cap_mode(4'h0),
    .xfer_ack(4'h0), .xfer_irq_keep(1'b0), .irq_en(4'hF), .irq_req(r_irq)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  initial begin
    {rd, wr, keep, wd, cmp, cap, mode, ack} = '0;
    en = 4'hF;
    {r_rd, r_wr, r_wd, r_cmp} = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset flags", rdata, 4'h0);
    check("R1 reset irq", irq, 4'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < 17; k++) begin
      @(negedge clk);
      rd = VECS[k].rd;   wr = VECS[k].wr;   wd = VECS[k].wd;
      cmp = VECS[k].cmp; cap = VECS[k].cap; mode = VECS[k].mode;
      ack = VECS[k].ack; keep = VECS[k].keep; en = VECS[k].en;
      step();
      check($sformatf("vector %0d flags", k), rdata, VECS[k].exp);
      check($sformatf("R9 vector %0d irq", k), irq, VECS[k].exp & VECS[k].en);
    end

    // R6: read and write in one cycle; the read arms nothing.
    @(negedge clk);
    {rd, wr, wd, cmp, cap, mode, ack, keep} = '0;
    en = 4'hF;
    rd = 1'b1; wr = 1'b1; wd = 4'hF;
    step();
    @(negedge clk);
    rd = 1'b0; wd = 4'h0;
    step();
    check("R6 same-cycle read does not arm", rdata, 4'hA);
    @(negedge clk);
    wr = 1'b0;

    // R10: reserved upper bits on the reduced variant.
    @(negedge clk);
    r_cmp = 4'hF;
    step();
    check("R10 reserved bits never set", r_rdata, 4'h3);
    check("R10 reserved irq zero", r_irq, 4'h3);
    @(negedge clk);
    r_cmp = 4'h0; r_rd = 1'b1;
    step();
    @(negedge clk);
    r_rd = 1'b0; r_wr = 1'b1; r_wd = 4'h0;
    step();
    check("R10 reserved variant read-clear", r_rdata, 4'h0);
    @(negedge clk);
    r_wr = 1'b0;

    // R1: reset mid-run clears everything.
    @(negedge clk);
    rst_n = 1'b0;
    step();
    check("R1 mid-run reset flags", rdata, 4'h0);
    check("R1 mid-run reset irq", irq, 4'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule